// File: doc/BRIEF.md
# Synchronized Multi-Ratio Clock Generator

This block turns one fast oscillator clock into three derived clocks: a core clock (divide by M), a bus clock (divide by X) and a feedback clock (divide by N). Software in a slower control domain writes new ratios whenever it wants. The block carries each request across into the oscillator domain. It then loads all three ratios together, so every derived clock changes frequency on the same rising edge. No derived clock shows a shortened high or low phase, and the oscillator keeps running throughout.

The oscillator side compares the synchronized request against the ratios it already holds. Only a real difference opens its capture registers, and they stay open for a single cycle. A captured set waits until all three dividers are one cycle from a common terminal count. It is loaded there, so the new periods start on the next edge that all three share. The feedback divider's terminal count also forces the core and bus dividers to reload, which keeps them phase-locked to it. For this to hold, N must be a whole multiple of both M and X.

Top module: `ratio_clkgen`

## Requirements
- R1: While the oscillator-side reset is asserted, all three derived clocks are low. After release, the dividers run at the default ratios of 2 (core), 4 (bus) and 8 (feedback), and all three start high on the same edge.
- R2: A write strobe in the control domain records the three 6-bit ratio fields. The oscillator side captures a new set only when the stable synchronized request differs from the set it holds, and the capture lasts exactly one oscillator cycle.
- R3: A captured set is loaded into all three dividers in the cycle just before their common terminal count. The new ratios take effect together on the next common rising edge.
- R4: A request field of zero is ignored, and that divider keeps its previous ratio. The other fields of the same write still apply.
- R5: For a ratio r of 2 or more, the output is high for ceil(r/2) oscillator cycles and low for floor(r/2) cycles, so its period is r cycles.
- R6: A ratio of 1 passes the oscillator clock through to that output.
- R7: Across any ratio change, every high or low phase of each derived clock has exactly the width set by either the old ratio or the new ratio.
- R8: Every rising edge of the feedback clock coincides with a rising edge of both the core clock and the bus clock. This assumes N is a multiple of M and X.
- R9: A request that arrives while an earlier one is still waiting replaces it. Only the latest set ever reaches the dividers.
- R10: The feedback divider's terminal count reloads the core and bus counters, which realigns them to the feedback clock.
- R11: Changes may follow each other within a few feedback periods, for example a 4:1 step down followed by a 2:1 step up. Each one takes effect cleanly, and no resynchronization is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctl_clk | input | 1 | Control-domain clock |
| ctl_rst_n | input | 1 | Control-domain reset, active low |
| ctl_wr | input | 1 | Write strobe for the ratio request |
| ctl_core_rat | input | 6 | Requested core ratio (0 = keep) |
| ctl_bus_rat | input | 6 | Requested bus ratio (0 = keep) |
| ctl_fb_rat | input | 6 | Requested feedback ratio (0 = keep) |
| osc_clk | input | 1 | Fast oscillator clock |
| osc_rst_n | input | 1 | Oscillator-domain reset, active low |
| core_clk | output | 1 | Derived core clock |
| bus_clk | output | 1 | Derived bus clock |
| fb_clk | output | 1 | Derived feedback clock |

## Verification
A stale or partly loaded ratio register shows up within one feedback period. It appears as a phase width that matches neither the old nor the new ratio, or as a feedback rising edge without a matching core or bus rising edge. A counter that misses its reload, or a pending set that is applied off the common edge, produces a runt pulse at the very next boundary. The sweep covers every divisor pair for a set of feedback ratios from 1 to 63. Each phase width and each rising-edge coincidence is checked continuously, both while the ratios change and once they have settled.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
    localparam int RAT_W = 6;
    typedef logic [RAT_W-1:0] ratio_t;
    typedef struct packed {
        ratio_t core;
        ratio_t bus;
        ratio_t fb;
    } ratio_set_t;
endpackage

// File: rtl/clkgen_req_xfer.sv
module clkgen_req_xfer
    import clkgen_pkg::*;
#(
    parameter ratio_set_t DEF_SET = '{core: 6'd2, bus: 6'd4, fb: 6'd8}
) (
    input  logic       ctl_clk,
    input  logic       ctl_rst_n,
    input  logic       ctl_wr,
    input  ratio_set_t ctl_req,
    input  logic       osc_clk,
    input  logic       osc_rst_n,
    input  logic       load,
    output ratio_set_t pend,
    output logic       pend_vld
);
    // control-domain request holding registers
    ratio_set_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (ctl_wr) begin
            if (ctl_req.core != '0) hold_d.core = ctl_req.core;
            if (ctl_req.bus  != '0) hold_d.bus  = ctl_req.bus;
            if (ctl_req.fb   != '0) hold_d.fb   = ctl_req.fb;
        end
    end

    always_ff @(posedge ctl_clk or negedge ctl_rst_n) begin
        if (!ctl_rst_n) hold_q <= DEF_SET;
        else            hold_q <= hold_d;
    end

    // oscillator-domain sampling, change detection and pending set
    typedef struct packed {
        ratio_set_t s1;
        ratio_set_t s2;
        ratio_set_t pend;
        logic       vld;
    } xfer_t;

    xfer_t x_d, x_q;
    logic  cap;

    always_comb begin
        x_d    = x_q;
        x_d.s1 = hold_q;
        x_d.s2 = x_q.s1;
        cap    = (x_q.s1 == x_q.s2) && (x_q.s2 != x_q.pend);
        if (cap) begin
            x_d.pend = x_q.s2;
            x_d.vld  = 1'b1;
        end else if (load) begin
            x_d.vld  = 1'b0;
        end
    end

    always_ff @(posedge osc_clk or negedge osc_rst_n) begin
        if (!osc_rst_n) begin
            x_q.s1   <= DEF_SET;
            x_q.s2   <= DEF_SET;
            x_q.pend <= DEF_SET;
            x_q.vld  <= 1'b0;
        end else begin
            x_q <= x_d;
        end
    end

    assign pend     = x_q.pend;
    assign pend_vld = x_q.vld;

    // R2
    one_cycle_capture_chk: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
        cap |=> !cap);

    // R4
    no_zero_pending_chk: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
        x_q.vld |-> (x_q.pend.core != '0 && x_q.pend.bus != '0 && x_q.pend.fb != '0));
endmodule

// File: rtl/clkgen_divider.sv
module clkgen_divider
    import clkgen_pkg::*;
#(
    parameter ratio_t DEF_RAT = 6'd2
) (
    input  logic   osc_clk,
    input  logic   osc_rst_n,
    input  logic   load,
    input  ratio_t new_rat,
    input  logic   sync_rst,
    output logic   pre,
    output logic   term,
    output logic   dclk
);
    typedef struct packed {
        ratio_t cnt;
        ratio_t rat;
        logic   ph;
        logic   byp;
    } div_t;

    div_t d_d, d_q;
    logic roll;

    always_comb begin
        d_d   = d_q;
        roll  = (d_q.cnt == '0) || sync_rst;
        d_d.cnt = roll ? ratio_t'(d_q.rat - 1'b1) : ratio_t'(d_q.cnt - 1'b1);
        // phase follows the period the next count belongs to (rat_q)
        d_d.ph  = (d_d.cnt >= (d_q.rat >> 1));
        d_d.byp = roll ? (d_q.rat == ratio_t'(1)) : d_q.byp;
        d_d.rat = load ? new_rat : d_q.rat;
    end

    always_ff @(posedge osc_clk or negedge osc_rst_n) begin
        if (!osc_rst_n) begin
            d_q.cnt <= '0;
            d_q.rat <= DEF_RAT;
            d_q.ph  <= 1'b0;
            d_q.byp <= 1'b0;
        end else begin
            d_q <= d_d;
        end
    end

    assign term = (d_q.cnt == '0);
    assign pre  = (d_q.cnt == ratio_t'(1)) || (d_q.rat == ratio_t'(1));
    assign dclk = d_q.byp ? osc_clk : d_q.ph;

    // R3
    load_at_preterm_chk: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
        load |-> pre);

    // R3
    ratio_only_on_load_chk: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
        (d_q.rat != $past(d_q.rat)) |-> $past(load));

    // R10
    sync_reload_chk: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
        sync_rst |=> (d_q.cnt == ratio_t'($past(d_q.rat) - 1'b1)));
endmodule

// File: rtl/ratio_clkgen.sv
module ratio_clkgen
    import clkgen_pkg::*;
#(
    parameter int DEF_CORE = 2,
    parameter int DEF_BUS  = 4,
    parameter int DEF_FB   = 8
) (
    input  logic             ctl_clk,
    input  logic             ctl_rst_n,
    input  logic             ctl_wr,
    input  logic [RAT_W-1:0] ctl_core_rat,
    input  logic [RAT_W-1:0] ctl_bus_rat,
    input  logic [RAT_W-1:0] ctl_fb_rat,
    input  logic             osc_clk,
    input  logic             osc_rst_n,
    output logic             core_clk,
    output logic             bus_clk,
    output logic             fb_clk
);
    localparam int NDIV = 3;
    localparam int FB_IDX = NDIV - 1;
    localparam ratio_t DEF_R [NDIV] = '{ratio_t'(DEF_CORE), ratio_t'(DEF_BUS), ratio_t'(DEF_FB)};
    localparam ratio_set_t DEF_SET = '{core: ratio_t'(DEF_CORE), bus: ratio_t'(DEF_BUS),
                                       fb: ratio_t'(DEF_FB)};

    ratio_set_t       req, pend;
    logic             pend_vld, load;
    ratio_t           pend_r [NDIV];
    logic [NDIV-1:0]  pre, term, dclk;

    assign req = '{core: ctl_core_rat, bus: ctl_bus_rat, fb: ctl_fb_rat};

    clkgen_req_xfer #(.DEF_SET(DEF_SET)) u_xfer (
        .ctl_clk   (ctl_clk),
        .ctl_rst_n (ctl_rst_n),
        .ctl_wr    (ctl_wr),
        .ctl_req   (req),
        .osc_clk   (osc_clk),
        .osc_rst_n (osc_rst_n),
        .load      (load),
        .pend      (pend),
        .pend_vld  (pend_vld)
    );

    assign pend_r[0] = pend.core;
    assign pend_r[1] = pend.bus;
    assign pend_r[2] = pend.fb;

    // load one cycle before the shared terminal count
    assign load = pend_vld && (&pre);

    for (genvar g = 0; g < NDIV; g++) begin : g_div
        logic srst;
        if (g == FB_IDX) begin : g_fb
            assign srst = 1'b0;
        end else begin : g_slave
            assign srst = term[FB_IDX];
        end
        clkgen_divider #(.DEF_RAT(DEF_R[g])) u_div (
            .osc_clk   (osc_clk),
            .osc_rst_n (osc_rst_n),
            .load      (load),
            .new_rat   (pend_r[g]),
            .sync_rst  (srst),
            .pre       (pre[g]),
            .term      (term[g]),
            .dclk      (dclk[g])
        );
    end

    assign core_clk = dclk[0];
    assign bus_clk  = dclk[1];
    assign fb_clk   = dclk[FB_IDX];

    // R8
    fb_edge_aligned_chk: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
        term[FB_IDX] |-> (term[0] && term[1]));
endmodule

// File: tb/tb_ratio_clkgen.sv
`timescale 1ns/1ps
module tb_ratio_clkgen;
    logic       ctl_clk = 1'b0, osc_clk = 1'b0;
    logic       ctl_rst_n = 1'b0, osc_rst_n = 1'b0, ctl_wr = 1'b0;
    logic [5:0] ctl_core_rat = '0, ctl_bus_rat = '0, ctl_fb_rat = '0;
    logic       core_clk, bus_clk, fb_clk;

    ratio_clkgen dut (
        .ctl_clk(ctl_clk), .ctl_rst_n(ctl_rst_n), .ctl_wr(ctl_wr),
        .ctl_core_rat(ctl_core_rat), .ctl_bus_rat(ctl_bus_rat), .ctl_fb_rat(ctl_fb_rat),
        .osc_clk(osc_clk), .osc_rst_n(osc_rst_n),
        .core_clk(core_clk), .bus_clk(bus_clk), .fb_clk(fb_clk)
    );

    always #5    osc_clk = ~osc_clk;
    always #13.5 ctl_clk = ~ctl_clk;

    int vectors = 0, miscompares = 0;
    int cur [3], ra [3], rb [3];
    int run [3], last_rise [3], rcount [3];
    bit started [3], prev [3];
    bit mon_on = 0, settled = 0, done = 0;
    int hidx = 0;
    event fb_rise_ev;
    string nm [3] = '{"core", "bus", "fb"};

    function automatic int hi_w(int r);
        return (r == 1) ? 1 : 2 * ((r + 1) / 2);
    endfunction
    function automatic int lo_w(int r);
        return (r == 1) ? 1 : 2 * (r / 2);
    endfunction

    task automatic sample();
        bit v [3];
        bit rose [3];
        v[0] = core_clk; v[1] = bus_clk; v[2] = fb_clk;
        hidx++;
        for (int k = 0; k < 3; k++) begin
            rose[k] = v[k] && !prev[k];
            if (v[k] != prev[k]) begin
                if (started[k]) begin
                    // R7 (and R5/R6 in steady state): completed phase width
                    int ea = prev[k] ? hi_w(ra[k]) : hi_w(ra[k]);
                    int eb;
                    ea = prev[k] ? hi_w(ra[k]) : lo_w(ra[k]);
                    eb = prev[k] ? hi_w(rb[k]) : lo_w(rb[k]);
                    vectors++;
                    if (run[k] != ea && run[k] != eb) begin
                        miscompares++;
                        $display("FAIL R7 %s %s width act=%0d halves exp=%0d or %0d",
                                 nm[k], prev[k] ? "high" : "low", run[k], ea, eb);
                    end
                end
                started[k] = 1;
                run[k] = 1;
            end else begin
                run[k]++;
            end
            if (rose[k]) begin
                if (settled && last_rise[k] >= 0) begin
                    vectors++;
                    if (hidx - last_rise[k] != 2 * cur[k]) begin
                        miscompares++;
                        $display("FAIL R5 %s period act=%0d halves exp=%0d",
                                 nm[k], hidx - last_rise[k], 2 * cur[k]);
                    end
                    rcount[k]++;
                end
                last_rise[k] = hidx;
            end
            prev[k] = v[k];
        end
        if (rose[2]) begin
            // R8 / R10: feedback edge aligned with core and bus edges
            vectors++;
            if (!(rose[0] && rose[1])) begin
                miscompares++;
                $display("FAIL R8 fb rise alone act=core%0d bus%0d exp=core1 bus1",
                         rose[0], rose[1]);
            end
            -> fb_rise_ev;
        end
    endtask

    initial begin
        for (int k = 0; k < 3; k++) begin
            prev[k] = 0; started[k] = 0; run[k] = 0; last_rise[k] = -1; rcount[k] = 0;
        end
        forever begin
            @(posedge osc_clk);
            #2.5;
            if (mon_on) sample();
            #5;
            if (mon_on) sample();
        end
    end

    task automatic ctl_write(int m, int x, int n);
        @(negedge ctl_clk);
        ctl_core_rat = 6'(m); ctl_bus_rat = 6'(x); ctl_fb_rat = 6'(n);
        ctl_wr = 1'b1;
        @(negedge ctl_clk);
        ctl_wr = 1'b0;
    endtask

    task automatic settle_and_check(int n_new, string tag);
        settled = 1;
        for (int k = 0; k < 3; k++) rcount[k] = 0;
        repeat (2 * n_new + 6) @(posedge osc_clk);
        for (int k = 0; k < 3; k++) begin
            vectors++;
            if (rcount[k] < 1) begin
                miscompares++;
                $display("FAIL %s %s settled periods act=%0d exp>=1", tag, nm[k], rcount[k]);
            end
        end
    endtask

    // full change: old and new ratios allowed until settled
    task automatic apply(int m, int x, int n, string tag);
        int nw [3];
        int old_n = cur[2];
        nw[0] = (m == 0) ? cur[0] : m;
        nw[1] = (x == 0) ? cur[1] : x;
        nw[2] = (n == 0) ? cur[2] : n;
        settled = 0;
        for (int k = 0; k < 3; k++) begin ra[k] = cur[k]; rb[k] = nw[k]; end
        ctl_write(m, x, n);
        repeat (2 * old_n + 2 * nw[2] + 40) @(posedge osc_clk);
        for (int k = 0; k < 3; k++) begin cur[k] = nw[k]; ra[k] = nw[k]; rb[k] = nw[k]; end
        settle_and_check(nw[2], tag);
    endtask

    initial begin
        cur = '{2, 4, 8}; ra = cur; rb = cur;
        repeat (4) @(posedge osc_clk);
        #2;
        // R1: all outputs low in reset
        vectors += 3;
        if (core_clk !== 1'b0) begin miscompares++; $display("FAIL R1 core in reset act=%b exp=0", core_clk); end
        if (bus_clk  !== 1'b0) begin miscompares++; $display("FAIL R1 bus in reset act=%b exp=0", bus_clk); end
        if (fb_clk   !== 1'b0) begin miscompares++; $display("FAIL R1 fb in reset act=%b exp=0", fb_clk); end
        ctl_rst_n = 1'b1;
        @(negedge osc_clk);
        osc_rst_n = 1'b1;
        mon_on = 1;
        repeat (30) @(posedge osc_clk);
        settle_and_check(8, "R1");

        // R4: zero core field keeps core at 2
        apply(0, 2, 4, "R4");

        // R2 R3 R5 R6 R7: sweep every divisor pair for a set of feedback ratios
        begin
            int nl [13] = '{1, 2, 3, 4, 6, 8, 12, 16, 24, 36, 48, 60, 63};
            foreach (nl[i]) begin
                for (int m = 1; m <= nl[i]; m++) begin
                    if (nl[i] % m == 0) apply(m, nl[i] / m, nl[i], "R3");
                end
            end
        end

        // R9: A overwritten by B before the common edge; A must never show
        apply(1, 2, 48, "R9");
        settled = 0;
        @(fb_rise_ev);
        for (int k = 0; k < 3; k++) ra[k] = cur[k];
        rb = '{4, 4, 8};
        ctl_write(2, 3, 6);
        ctl_write(4, 4, 8);
        repeat (2 * 48 + 2 * 8 + 40) @(posedge osc_clk);
        cur = '{4, 4, 8}; ra = cur; rb = cur;
        settle_and_check(8, "R9");

        // R11: 4:1 step down then 2:1 step up, closely spaced
        apply(1, 2, 2, "R11");
        settled = 0;
        ra = cur; rb = '{4, 8, 8};
        ctl_write(4, 8, 8);
        repeat (2 + 20) @(posedge osc_clk);
        cur = '{4, 8, 8};
        apply(2, 4, 4, "R11");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule